// File: doc/BRIEF.md
# Voltage Code Slew Ramp

This block produces the digital code for a regulator's reference DAC. The code moves toward a requested target one LSB at a time, and a prescaler sets the pace. A command carries a target and a type, and each type uses its own division of the base (fast) step period:

- fast sets run at the base rate;
- slow sets use a selectable binary division;
- soft-start ramps run four times slower than fast;
- the fault shutdown ramp runs sixteen times slower than fast and goes to zero.

After reset the block reads a boot-voltage select once. It then soft-starts to one of two boot codes. Later changes of that select have no effect. A shutdown command latches: the code winds down to zero and every later command is ignored until the next reset. An output flag reports when the code has reached the target.

Top module: `vid_ramp_gen`

## Requirements
- R1: While `rst_n` is low, `dac_code` is 0 and `at_target` is 1.
- R2: The first clock edge after reset release samples `boot_hi`. The block then ramps toward `BOOT_HI` (135) if `boot_hi` is 1, or toward `BOOT_LO` (90) if it is 0, at the soft-start period of 4*BASE_DIV cycles per step. Later changes of `boot_hi` have no effect.
- R3: The code changes by exactly one LSB per prescaler tick, in either direction, and never passes the target. Counting the command edge as cycle 0, the first step lands on the edge P cycles after it, where P is the step period.
- R4: `cmd_type` 2'b00 (fast set) uses P = BASE_DIV.
- R5: `cmd_type` 2'b01 (slow set) uses P = BASE_DIV*2, *4, *8 or *16 for `slow_sel` 2'b00, 2'b01, 2'b10 or 2'b11. `slow_sel` is sampled with the command.
- R6: `cmd_type` 2'b10 (soft-start set) uses P = BASE_DIV*4.
- R7: `cmd_type` 2'b11 (shutdown) sets the target to 0 with P = BASE_DIV*16 and latches. Later commands are ignored until reset.
- R8: `at_target` is high in exactly those cycles in which `dac_code` equals the current target.
- R9: A command that arrives mid-ramp replaces the target and restarts the prescaler on that edge. The ramp continues from the present code.
- R10: A target above `MAX_CODE` (230) is clamped to `MAX_CODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_hi | input | 1 | Boot select, sampled once after reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_type | input | 2 | 00 fast, 01 slow, 10 soft-start, 11 shutdown |
| cmd_target | input | CODE_W | Requested code |
| slow_sel | input | 2 | Slow-rate division select |
| dac_code | output | CODE_W | Present DAC code |
| at_target | output | 1 | Code equals target |

## Verification
A command is taken on the clock edge where `cmd_valid` is high. The code for that edge is unchanged, and step n lands on the edge n*P cycles later. The bench keeps the count of edges since the last accepted command. On each falling edge it computes the expected code arithmetically as the start code moved by floor(elapsed/P), limited to the target, and compares both outputs. The boot ramp counts its cycle 0 as the first edge after reset release. A command that arrives while shutdown is latched only advances the count, so the code keeps falling and then holds at zero.

// File: rtl/vid_ramp_gen.sv
module vid_ramp_gen #(
  parameter int CODE_W   = 8,
  parameter int BASE_DIV = 4,
  parameter int MAX_CODE = 230,
  parameter int BOOT_LO  = 90,
  parameter int BOOT_HI  = 135
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_hi,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_type,
  input  logic [CODE_W-1:0] cmd_target,
  input  logic [1:0]        slow_sel,
  output logic [CODE_W-1:0] dac_code,
  output logic              at_target
);
  localparam int PW = $clog2(BASE_DIV * 16) + 1;
  localparam logic [CODE_W-1:0] MAXC  = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] BLO   = CODE_W'(BOOT_LO);
  localparam logic [CODE_W-1:0] BHI   = CODE_W'(BOOT_HI);
  localparam logic [PW-1:0]     BASEP = PW'(BASE_DIV);

  logic [CODE_W-1:0] code_q, tgt_q, cmd_tgt;
  logic [PW-1:0]     cnt_q, per_q, cmd_per;
  logic [2:0]        cmd_shift;
  logic              started_q, fault_q, tick;

  always_comb begin
    case (cmd_type)
      2'b00:   cmd_shift = 3'd0;
      2'b01:   cmd_shift = {1'b0, slow_sel} + 3'd1;
      2'b10:   cmd_shift = 3'd2;
      default: cmd_shift = 3'd4;
    endcase
  end

  assign cmd_per   = BASEP << cmd_shift;
  assign cmd_tgt   = (cmd_type == 2'b11) ? '0 : ((cmd_target > MAXC) ? MAXC : cmd_target);
  assign tick      = (cnt_q == per_q - PW'(1));
  assign dac_code  = code_q;
  assign at_target = (code_q == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      tgt_q     <= '0;
      cnt_q     <= '0;
      per_q     <= BASEP;
      started_q <= 1'b0;
      fault_q   <= 1'b0;
    end else if (!started_q) begin
      started_q <= 1'b1;
      tgt_q     <= boot_hi ? BHI : BLO;
      per_q     <= BASEP << 2;
      cnt_q     <= '0;
    end else if (cmd_valid && !fault_q) begin
      tgt_q   <= cmd_tgt;
      per_q   <= cmd_per;
      cnt_q   <= '0;
      fault_q <= (cmd_type == 2'b11);
    end else if (tick) begin
      cnt_q <= '0;
      if (code_q < tgt_q)      code_q <= code_q + CODE_W'(1);
      else if (code_q > tgt_q) code_q <= code_q - CODE_W'(1);
    end else begin
      cnt_q <= cnt_q + PW'(1);
    end
  end
endmodule

// File: rtl/vid_ramp_gen_chk.sv
module vid_ramp_gen_chk #(
  parameter int CODE_W   = 8,
  parameter int MAX_CODE = 230
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              fault_q,
  input logic [CODE_W-1:0] dac_code,
  input logic              at_target
);
  p_one_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == $past(dac_code)) || (dac_code == $past(dac_code) + CODE_W'(1)) ||
    (dac_code == $past(dac_code) - CODE_W'(1)));

  p_hold_at_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_target && !cmd_valid) |=> $stable(dac_code));

  p_shutdown_falls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> (dac_code <= $past(dac_code)));

  p_code_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dac_code <= CODE_W'(MAX_CODE));
endmodule

bind vid_ramp_gen vid_ramp_gen_chk #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .fault_q(fault_q),
  .dac_code(dac_code), .at_target(at_target));

// File: tb/test_vid_ramp_gen.sv
module test_vid_ramp_gen;
  localparam int BD = 2;
  logic clk = 0, rst_n = 0, boot_hi = 0, cmd_valid = 0;
  logic [1:0] cmd_type = 0, slow_sel = 0;
  logic [7:0] cmd_target = 0;
  logic [7:0] dac_code;
  logic at_target;
  int checks = 0, fails = 0;
  int m_start, m_tgt, m_per, m_el;
  bit m_fault;

  always #2.5 clk = ~clk;

  vid_ramp_gen #(.CODE_W(8), .BASE_DIV(BD)) i_vid_ramp_gen (
    .clk(clk), .rst_n(rst_n), .boot_hi(boot_hi), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_target(cmd_target), .slow_sel(slow_sel),
    .dac_code(dac_code), .at_target(at_target));

  function automatic int expv(int s, int t, int el, int p);
    int n = el / p;
    if (t >= s) return (s + n > t) ? t : s + n;
    return (s - n < t) ? t : s - n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_now(string tag);
    int e = expv(m_start, m_tgt, m_el, m_per);
    chk(dac_code == e, tag, dac_code, e);
    chk(at_target == (e == m_tgt), "R8 at_target", at_target, e == m_tgt);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); m_el++;
      @(negedge clk); check_now(tag);
    end
  endtask

  task automatic issue(int ty, int tgt, int sel, string tag);
    int sh;
    cmd_valid = 1; cmd_type = 2'(ty); cmd_target = 8'(tgt); slow_sel = 2'(sel);
    @(posedge clk);
    if (!m_fault) begin
      m_start = expv(m_start, m_tgt, m_el, m_per);
      m_tgt = (ty == 3) ? 0 : ((tgt > 230) ? 230 : tgt);
      sh = (ty == 0) ? 0 : (ty == 1) ? sel + 1 : (ty == 2) ? 2 : 4;
      m_per = BD << sh;
      m_el = 0;
      m_fault = (ty == 3);
    end else m_el++;
    @(negedge clk); cmd_valid = 0;
    check_now(tag);
  endtask

  task automatic do_reset(bit hi);
    rst_n = 0; boot_hi = hi;
    repeat (3) @(negedge clk);
    chk(dac_code == 0, "R1 reset code", dac_code, 0);
    chk(at_target == 1, "R1 reset flag", at_target, 1);
    rst_n = 1;
    @(posedge clk);
    m_start = 0; m_tgt = hi ? 135 : 90; m_per = BD * 4; m_el = 0; m_fault = 0;
    @(negedge clk); check_now("R2 boot");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(0);
    idle(90 * BD * 4 + 10, "R2 R3 boot ramp low");
    boot_hi = 1;
    idle(20, "R2 boot select ignored");
    issue(0, 200, 0, "R4 fast up");
    idle(110 * BD + 6, "R4 R3 fast up");
    issue(0, 250, 0, "R10 clamp");
    idle(30 * BD + 6, "R10 clamp");
    issue(1, 180, 0, "R5 sel0");
    idle(50 * BD * 2 + 6, "R5 sel0 down");
    issue(1, 200, 1, "R5 sel1");
    idle(20 * BD * 4 + 6, "R5 sel1 up");
    issue(1, 170, 2, "R5 sel2");
    idle(30 * BD * 8 + 6, "R5 sel2 down");
    issue(1, 190, 3, "R5 sel3");
    idle(20 * BD * 16 + 6, "R5 sel3 up");
    issue(2, 150, 0, "R6 soft");
    idle(40 * BD * 4 + 6, "R6 soft down");
    issue(0, 200, 0, "R9 first");
    idle(15, "R9 partial");
    issue(1, 100, 0, "R9 redirect");
    idle(110 * BD * 2 + 6, "R9 redirect ramp");
    issue(0, 100, 0, "R8 same target");
    idle(10, "R8 same target hold");
    issue(3, 0, 0, "R7 shutdown");
    idle(BD * 16 * 20, "R7 partial");
    issue(0, 200, 0, "R7 ignored mid");
    idle(80 * BD * 16 + 6, "R7 to zero");
    issue(0, 200, 0, "R7 ignored");
    idle(50, "R7 held zero");
    do_reset(1);
    idle(135 * BD * 4 + 10, "R2 boot ramp high");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule